// File: doc/BRIEF.md
# Sliding-Window String Matcher with Parallel Compare Dictionary

This block finds repeated byte strings for a dictionary-style compressor. It takes one byte per clock on a valid/ready input. Every byte is compared in the same cycle against each entry of a shift-register window of recent bytes. Each window cell keeps a flag that says whether it still continues the string being matched. A string ends when no flag survives the incoming byte. At that point the block emits a token with the distance code and the length of the string. A byte that has no earlier occurrence in the window leaves as a literal.

Once processed, a byte enters the window at cell 0 and all older bytes move one cell further. The byte in the last cell drops out. Cell `i` therefore holds the byte `i+1` positions before the byte being compared. The reported position is that cell index. When several cells continue the string, the lowest index wins, which is the nearest occurrence. Strings are capped at a parameter length. A flush input closes the open string and empties the window, so the next block of data shares no history with the previous one.

Top module: `lzm_engine`

## Requirements
- R1: After reset no token is emitted, `in_ready` is high and the window holds no valid entries, so the first byte that follows leaves as a literal.
- R2: `in_ready` equals the inverse of `flush`. A byte is consumed on every clock edge where `in_valid` and `in_ready` are both high, with no extra wait states. A byte offered while `flush` is high is not consumed.
- R3: A consumed byte that is not in any valid window cell, while no string is open, produces one token on the next clock: `tok_len`=0, `tok_lit_valid`=1, and `tok_lit` equal to the byte.
- R4: An open string extends only when the new byte equals the byte held in the same window cell that matched the previous byte, so the distance stays constant. The internal length counts the bytes of the string.
- R5: If a consumed byte fails to extend the open string, a token appears on the next clock. Its `tok_len` is the string length and its `tok_pos` is the cell index, that is distance minus one. If the breaking byte occurs in the window, it opens a new string and `tok_lit_valid`=0. Otherwise the same token carries it with `tok_lit_valid`=1.
- R6: When several cells continue the string at its end, `tok_pos` reports the lowest cell index, which is the most recent occurrence.
- R7: The byte that brings the length to `MAX_LEN` causes a token with `tok_len`=`MAX_LEN` on the next clock. The following byte starts matching afresh. `tok_len` never exceeds `MAX_LEN`.
- R8: A clock edge with `flush` high emits the token of an open string (`tok_lit_valid`=0) on the next clock, and no token if no string is open. It also leaves the window empty and no string open.
- R9: Empty window cells and bytes more than `DEPTH` positions back never match. A byte exactly `DEPTH` back does match.
- R10: No token is emitted on a clock that follows a byte that extends the string below the cap, or a byte that opens a string.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte accepted this cycle (low during flush) |
| in_sym | input | 8 | Input byte |
| flush | input | 1 | Close the open string and empty the window |
| tok_valid | output | 1 | Token present, one-cycle pulse |
| tok_len | output | $clog2(MAX_LEN+1) | String length, 0 for a literal-only token |
| tok_pos | output | $clog2(DEPTH) | Cell index of the match (distance minus one) |
| tok_lit_valid | output | 1 | `tok_lit` carries a literal byte |
| tok_lit | output | 8 | Literal byte |

## Verification
Each token is registered, so it is due exactly one clock after the edge that consumed the byte (literal, string end, cap) or that saw `flush`. A byte that extends or opens a string is due no token at all. The driver changes inputs on falling edges and pushes the expected token into a queue at the moment the byte is offered. The monitor checks outputs on the following falling edge, pops the queue and compares. A `tok_valid` with an empty queue fails as a spurious token. Expected tokens come from a history-array matcher that tries each distance from 1 to `DEPTH` over the whole string, independently of the cell flags.

// File: rtl/lzm_pkg.sv
package lzm_pkg;

  localparam int SYM_W = 8;

  // Kind of token produced by one consumed byte or one flush.
  typedef enum logic [1:0] {
    TK_NONE,
    TK_LIT,
    TK_MATCH,
    TK_MATCH_LIT
  } tok_kind_e;

  // Kind selection kept as a function so the rule reads in one place.
  function automatic tok_kind_e pick_kind(input logic str_out, input logic lit_out);
    if (str_out && lit_out) return TK_MATCH_LIT;
    if (str_out)            return TK_MATCH;
    if (lit_out)            return TK_LIT;
    return TK_NONE;
  endfunction

endpackage

// File: rtl/lzm_window.sv
module lzm_window #(
  parameter int DEPTH = 32,
  parameter int SYM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             clear,
  input  logic [SYM_W-1:0] sym,
  output logic [DEPTH-1:0] hit
);

  logic [SYM_W-1:0] cell_q [DEPTH];
  logic [DEPTH-1:0] full_q;

  // Cell 0 takes the newest byte; the last cell falls off.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
    end else if (clear) begin
      full_q <= '0;
    end else if (push) begin
      full_q <= {full_q[DEPTH-2:0], 1'b1};
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (i == 0) begin : g_head
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)    cell_q[0] <= '0;
          else if (push) cell_q[0] <= sym;
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)    cell_q[i] <= '0;
          else if (push) cell_q[i] <= cell_q[i-1];
        end
      end
      // Parallel compare, one per cell; empty cells never hit.
      assign hit[i] = full_q[i] && (cell_q[i] == sym);
    end
  endgenerate

endmodule

// File: rtl/lzm_prio.sv
module lzm_prio #(
  parameter int N = 32,
  parameter int W = 5
) (
  input  logic [N-1:0] req,
  output logic [W-1:0] idx
);

  // Lowest set index wins; scanning downward lets the lowest overwrite.
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end

endmodule

// File: rtl/lzm_ctrl.sv
module lzm_ctrl
  import lzm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int MAX_LEN = 16,
  parameter int POS_W   = 5,
  parameter int LEN_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             flush,
  input  logic [SYM_W-1:0] sym,
  input  logic [DEPTH-1:0] hit,
  output logic             tok_valid,
  output logic [LEN_W-1:0] tok_len,
  output logic [POS_W-1:0] tok_pos,
  output logic             tok_lit_valid,
  output logic [SYM_W-1:0] tok_lit,
  output logic [LEN_W-1:0] cur_len,
  output logic             string_end,
  output logic             cont_any
);

  logic [DEPTH-1:0] chain_q, chain_d, cont;
  logic [LEN_W-1:0] len_d;
  logic [POS_W-1:0] pos_hold, pos_cont;
  logic             hit_any, str_out, lit_out;
  logic [LEN_W-1:0] out_len;
  logic [POS_W-1:0] out_pos;
  tok_kind_e        kind;

  // A cell continues only if it held the previous byte of the string.
  assign cont       = hit & chain_q;
  assign cont_any   = |cont;
  assign hit_any    = |hit;
  assign string_end = (cur_len != '0) && !cont_any;

  lzm_prio #(.N(DEPTH), .W(POS_W)) u_prio_hold (.req(chain_q), .idx(pos_hold));
  lzm_prio #(.N(DEPTH), .W(POS_W)) u_prio_cont (.req(cont),    .idx(pos_cont));

  always_comb begin
    chain_d = chain_q;
    len_d   = cur_len;
    str_out = 1'b0;
    lit_out = 1'b0;
    out_len = cur_len;
    out_pos = pos_hold;
    if (flush) begin
      str_out = (cur_len != '0);
      chain_d = '0;
      len_d   = '0;
    end else if (accept) begin
      if (cur_len == '0) begin
        if (hit_any) begin
          chain_d = hit;
          len_d   = LEN_W'(1);
        end else begin
          lit_out = 1'b1;
          out_len = '0;
        end
      end else if (cont_any) begin
        if (cur_len == LEN_W'(MAX_LEN - 1)) begin
          str_out = 1'b1;
          out_len = LEN_W'(MAX_LEN);
          out_pos = pos_cont;
          chain_d = '0;
          len_d   = '0;
        end else begin
          chain_d = cont;
          len_d   = cur_len + 1'b1;
        end
      end else begin
        str_out = 1'b1;
        if (hit_any) begin
          chain_d = hit;
          len_d   = LEN_W'(1);
        end else begin
          lit_out = 1'b1;
          chain_d = '0;
          len_d   = '0;
        end
      end
    end
  end

  assign kind = pick_kind(str_out, lit_out);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q       <= '0;
      cur_len       <= '0;
      tok_valid     <= 1'b0;
      tok_len       <= '0;
      tok_pos       <= '0;
      tok_lit_valid <= 1'b0;
      tok_lit       <= '0;
    end else begin
      chain_q       <= chain_d;
      cur_len       <= len_d;
      tok_valid     <= (kind != TK_NONE);
      tok_len       <= (kind == TK_LIT) ? '0 : out_len;
      tok_pos       <= (kind == TK_LIT) ? '0 : out_pos;
      tok_lit_valid <= (kind == TK_LIT) || (kind == TK_MATCH_LIT);
      tok_lit       <= lit_out ? sym : '0;
    end
  end

endmodule

// File: rtl/lzm_engine.sv
module lzm_engine
  import lzm_pkg::*;
#(
  parameter int DEPTH   = 32,
  parameter int MAX_LEN = 16,
  localparam int POS_W  = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_sym,
  input  logic             flush,
  output logic             tok_valid,
  output logic [LEN_W-1:0] tok_len,
  output logic [POS_W-1:0] tok_pos,
  output logic             tok_lit_valid,
  output logic [SYM_W-1:0] tok_lit
);

  logic             accept;
  logic [DEPTH-1:0] hit;
  logic [LEN_W-1:0] cur_len;
  logic             string_end, cont_any;

  assign in_ready = !flush;
  assign accept   = in_valid && in_ready;

  lzm_window #(.DEPTH(DEPTH), .SYM_W(SYM_W)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (accept),
    .clear (flush),
    .sym   (in_sym),
    .hit   (hit)
  );

  lzm_ctrl #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .POS_W(POS_W), .LEN_W(LEN_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .accept        (accept),
    .flush         (flush),
    .sym           (in_sym),
    .hit           (hit),
    .tok_valid     (tok_valid),
    .tok_len       (tok_len),
    .tok_pos       (tok_pos),
    .tok_lit_valid (tok_lit_valid),
    .tok_lit       (tok_lit),
    .cur_len       (cur_len),
    .string_end    (string_end),
    .cont_any      (cont_any)
  );

endmodule

// File: rtl/lzm_engine_chk.sv
module lzm_engine_chk #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             flush,
  input logic             tok_valid,
  input logic [LEN_W-1:0] tok_len,
  input logic             tok_lit_valid,
  input logic [LEN_W-1:0] cur_len,
  input logic             string_end
);

  logic acc;
  assign acc = in_valid && in_ready;

  assert_flush_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  assert_token_has_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> $past(acc || flush));

  assert_literal_form_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_len == '0) |-> tok_lit_valid);

  assert_end_emits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && string_end) |=> (tok_valid && tok_len == $past(cur_len)));

  assert_len_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> (tok_len <= LEN_W'(MAX_LEN) && cur_len < LEN_W'(MAX_LEN)));

  assert_flush_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cur_len == '0));

  assert_extend_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cur_len != '0 && !string_end && cur_len < LEN_W'(MAX_LEN - 1))
      |=> (!tok_valid && cur_len == $past(cur_len) + 1'b1));

endmodule

bind lzm_engine lzm_engine_chk #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .flush         (flush),
  .tok_valid     (tok_valid),
  .tok_len       (tok_len),
  .tok_lit_valid (tok_lit_valid),
  .cur_len       (cur_len),
  .string_end    (string_end)
);

// File: tb/lzm_engine_tb.sv
module lzm_engine_tb;

  localparam int DEPTH   = 32;
  localparam int MAX_LEN = 16;
  localparam int POS_W   = $clog2(DEPTH);
  localparam int LEN_W   = $clog2(MAX_LEN + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_sym = '0;
  logic             flush = 1'b0;
  logic             tok_valid;
  logic [LEN_W-1:0] tok_len;
  logic [POS_W-1:0] tok_pos;
  logic             tok_lit_valid;
  logic [7:0]       tok_lit;

  always #5 clk = ~clk;

  lzm_engine #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym(in_sym), .flush(flush), .tok_valid(tok_valid), .tok_len(tok_len),
    .tok_pos(tok_pos), .tok_lit_valid(tok_lit_valid), .tok_lit(tok_lit)
  );

  typedef struct {
    int    len;
    int    pos;
    bit    lv;
    int    lit;
    string tag;
  } exp_t;

  exp_t  expq[$];
  int    checks = 0;
  int    errors = 0;
  string phase  = "R1";
  bit    done   = 1'b0;

  // Reference matcher: plain history array, each distance tried over the whole string.
  logic [7:0] hist [0:16383];
  int t = 0, blk = 0, rl = 0, rt0 = 0;

  function automatic bit dist_ok(int d, int t0, int n);
    for (int k = 0; k < n; k++) begin
      if (t0 + k - d < blk) return 1'b0;
      if (hist[t0 + k - d] != hist[t0 + k]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic int min_dist(int t0, int n);
    for (int d = 1; d <= DEPTH; d++) if (dist_ok(d, t0, n)) return d;
    return 0;
  endfunction

  task automatic push_exp(int len, int pos, bit lv, int lit, string kind);
    exp_t e;
    e.len = len; e.pos = pos; e.lv = lv; e.lit = lit;
    e.tag = {kind, " ", phase};
    expq.push_back(e);
  endtask

  task automatic ref_sym(logic [7:0] s);
    int d, dp;
    hist[t] = s;
    if (rl == 0) begin
      if (min_dist(t, 1) != 0) begin rt0 = t; rl = 1; end
      else push_exp(0, 0, 1'b1, s, "R3");
    end else begin
      d = min_dist(rt0, rl + 1);
      if (d != 0) begin
        rl++;                                   // R4 constant-distance extension
        if (rl == MAX_LEN) begin
          push_exp(MAX_LEN, d - 1, 1'b0, 0, "R7");
          rl = 0;
        end
      end else begin
        dp = min_dist(rt0, rl);                 // R6 nearest distance
        if (min_dist(t, 1) != 0) begin
          push_exp(rl, dp - 1, 1'b0, 0, "R5 R6");
          rt0 = t; rl = 1;
        end else begin
          push_exp(rl, dp - 1, 1'b1, s, "R5 R6");
          rl = 0;
        end
      end
    end
    t++;
  endtask

  task automatic send(logic [7:0] s);
    in_valid = 1'b1;
    in_sym   = s;
    flush    = 1'b0;
    ref_sym(s);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R8 flush; with_sym offers a byte that must not be consumed (R2).
  task automatic do_flush(bit with_sym);
    flush    = 1'b1;
    in_valid = with_sym;
    in_sym   = 8'hEE;
    #1;
    checks++;
    if (in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R2 in_ready during flush: got %b expected 0", in_ready);
    end
    if (rl > 0) push_exp(rl, min_dist(rt0, rl) - 1, 1'b0, 0, "R8");
    rl  = 0;
    blk = t;
    @(negedge clk);
    flush    = 1'b0;
    in_valid = 1'b0;
  endtask

  // Scoreboard monitor: outputs are sampled on falling edges.
  always @(negedge clk) begin
    if (rst_n && tok_valid) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL R10 spurious token: got len=%0d pos=%0d lv=%b expected none",
                 tok_len, tok_pos, tok_lit_valid);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (int'(tok_len) != e.len || (e.len > 0 && int'(tok_pos) != e.pos) ||
            tok_lit_valid !== e.lv || (e.lv && int'(tok_lit) != e.lit)) begin
          errors++;
          $display("FAIL %s token: got len=%0d pos=%0d lv=%b lit=%02h expected len=%0d pos=%0d lv=%b lit=%02h",
                   e.tag, tok_len, tok_pos, tok_lit_valid, tok_lit, e.len, e.pos, e.lv, e.lit);
        end
      end
    end
  end

  task automatic drain();
    repeat (4) @(negedge clk);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s missing tokens: got %0d outstanding expected 0", phase, expq.size());
      expq.delete();
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checks++;
    if (tok_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: got tok_valid=%b in_ready=%b expected 0 1", tok_valid, in_ready);
    end
    phase = "R1";
    send(8'h41);                      // empty window: literal

    phase = "R3";
    for (int i = 0; i < 8; i++) send(8'h10 + 8'(i));

    phase = "R4";
    for (int r = 0; r < 2; r++) for (int i = 0; i < 5; i++) send(8'h60 + 8'(i));
    send(8'hF0);                      // breaks, new literal rides in token (R5)

    phase = "R6";                     // same string at two distances
    for (int r = 0; r < 3; r++) begin send(8'h31); send(8'h32); send(8'h33); end
    send(8'h34);

    phase = "R7";
    for (int i = 0; i < 2 * MAX_LEN + 5; i++) send(8'h55);
    send(8'h56);
    drain();

    phase = "R8";
    send(8'h21); send(8'h22); send(8'h21); send(8'h22);
    do_flush(1'b1);                   // open string closed; byte EE refused
    send(8'hEE);                      // must be literal on empty window
    send(8'h21);                      // history gone: literal
    do_flush(1'b0);                   // no string open: no token
    drain();

    phase = "R9";                     // distance DEPTH+1 misses, DEPTH hits
    send(8'h77);
    for (int i = 0; i < DEPTH; i++) send(8'h80 + 8'(i));
    send(8'h77);
    do_flush(1'b0);
    send(8'h77);
    for (int i = 0; i < DEPTH - 1; i++) send(8'h80 + 8'(i));
    send(8'h77);
    send(8'hC5);
    do_flush(1'b0);
    drain();

    phase = "R5";                     // mixed traffic from a small alphabet
    for (int n = 0; n < 3000; n++) begin
      if (($urandom % 97) == 0) do_flush(($urandom % 2) == 1);
      else send(8'h40 + 8'($urandom % 4));
    end
    do_flush(1'b0);
    drain();

    phase = "R10";
    for (int n = 0; n < 1500; n++) send(8'h40 + 8'($urandom % 2));
    do_flush(1'b0);
    drain();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule